// File: doc/BRIEF.md
# Coprocessor Data Address Translator

This block turns a data address seen by a small coprocessor into a physical location. A valid address falls in one of two windows. The low window is the on-chip data tightly-coupled memory (TCM), and it is relocated by a fixed TCM offset. The window above it holds an external extension buffer. Addresses there are rebased onto a programmable, page-aligned base.

Address zero is rejected, and so is any address beyond the end of the external window. The result appears one clock after the request. It carries a target code, the translated address and an error flag.

The external base is loaded through a write-enable port. The port takes a raw value and a high-memory mode bit. Only the page bits of the value are kept. When high-memory mode is set, a fixed high-memory offset is added to the base. The composed base is held in one register, so translation never waits on that sum.

Top module: `cpdata_xlat`

## Requirements
- R1: After synchronous reset, `out_valid`, `out_target`, `out_addr` and `out_err` are all 0. The external base and the high-memory mode bit are also 0, so external offset 0 translates to address 0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R3: A request for address 0 produces `out_err` = 1.
- R4: A request for an address greater than TCM_BYTES + EXT_BYTES produces `out_err` = 1. The address exactly equal to TCM_BYTES + EXT_BYTES is accepted.
- R5: An address from 1 to TCM_BYTES-1 gives `out_target` = 2'd1 (TCM) and `out_addr` = address + TCM_OFFSET (default 0x18000, with default sizes of 32 KiB TCM and 4 MiB external).
- R6: An address from TCM_BYTES to TCM_BYTES + EXT_BYTES gives `out_target` = 2'd2 (external) and `out_addr` = base + (address - TCM_BYTES), taken modulo 2^32.
- R7: A configuration write keeps only bits 31:12 of `cfg_base`. Bits 11:0 of the stored base are zero.
- R8: When `cfg_high` is 1 at the write, HIGH_OFFSET (default 0x40000000) is added to the stored base, modulo 2^32.
- R9: When `out_err` is 1, `out_target` is 2'd0 (idle) and `out_addr` is 0. When `out_valid` is 0, all three of `out_target`, `out_addr` and `out_err` are 0.
- R10: A write at a clock edge affects only requests sampled at later edges. A request sampled at the same edge uses the old base. While `cfg_we` is 0, changes on `cfg_base` and `cfg_high` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load external base and high-memory mode |
| cfg_base | input | 32 | Raw external base value (page bits kept) |
| cfg_high | input | 1 | High-memory mode bit for the write |
| in_valid | input | 1 | Request valid |
| in_addr | input | 32 | Coprocessor data address |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_target | output | 2 | 0 idle, 1 TCM, 2 external |
| out_addr | output | 32 | Translated address |
| out_err | output | 1 | Address rejected |

## Verification
A stored base that is corrupted shows up only on external-window results. It stays hidden until the first external request after the write, and then appears on `out_addr` one cycle later. For that reason, every base setting is followed by a full sweep of both windows.

A wrong window boundary or limit compare shows up on `out_target` or `out_err` for exactly the addresses next to that edge. The sweeps are exhaustive across both edges and the zero address, so such a fault appears in the first result past the faulty edge.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int ADDR_W    = 32;
    localparam int PAGE_BITS = 12;

    typedef enum logic [1:0] {
        TGT_IDLE = 2'd0,
        TGT_TCM  = 2'd1,
        TGT_EXT  = 2'd2
    } tgt_e;

    typedef enum logic [1:0] {
        WIN_ZERO = 2'd0,
        WIN_TCM  = 2'd1,
        WIN_EXT  = 2'd2,
        WIN_OVER = 2'd3
    } win_e;

    typedef struct packed {
        logic              valid;
        tgt_e              tgt;
        logic [ADDR_W-1:0] addr;
        logic              err;
    } xlat_res_s;

    localparam xlat_res_s RES_IDLE = '{valid: 1'b0, tgt: TGT_IDLE, addr: '0, err: 1'b0};

    function automatic logic [ADDR_W-1:0] page_of(input logic [ADDR_W-1:0] v);
        return {v[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/xlat_base_reg.sv
module xlat_base_reg
    import xlat_pkg::*;
#(
    parameter logic [ADDR_W-1:0] HIGH_OFFSET = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              high,
    output logic [ADDR_W-1:0] base
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] base_d;
    logic              unused_low;

    assign unused_low = ^wdata[PAGE_BITS-1:0];

    generate
        if (HIGH_OFFSET == '0) begin : g_no_high
            logic unused_high;
            assign unused_high = high;
            assign base_d = page_of(wdata);
        end else begin : g_high
            assign base_d = page_of(wdata) + (high ? HIGH_OFFSET : '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (we) begin
            base_q <= base_d;
        end
    end

    assign base = base_q;

    AST_BASE_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        base_q[PAGE_BITS-1:0] == '0); // R7

    AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(base_q)); // R10

endmodule

// File: rtl/xlat_classify.sv
module xlat_classify
    import xlat_pkg::*;
#(
    parameter int unsigned TCM_BYTES = 32768,
    parameter int unsigned EXT_BYTES = 4194304
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win
);

    localparam logic [ADDR_W-1:0] TCM_END = ADDR_W'(TCM_BYTES);
    localparam logic [ADDR_W-1:0] LIMIT   = ADDR_W'(TCM_BYTES + EXT_BYTES);

    always_comb begin
        if (addr == '0) begin
            win = WIN_ZERO;
        end else if (addr > LIMIT) begin
            win = WIN_OVER;
        end else if (addr < TCM_END) begin
            win = WIN_TCM;
        end else begin
            win = WIN_EXT;
        end
    end

endmodule

// File: rtl/xlat_compose.sv
module xlat_compose
    import xlat_pkg::*;
#(
    parameter int unsigned       TCM_BYTES  = 32768,
    parameter logic [ADDR_W-1:0] TCM_OFFSET = 32'h0001_8000
) (
    input  logic              valid,
    input  win_e              win,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    output xlat_res_s         res
);

    localparam logic [ADDR_W-1:0] TCM_END = ADDR_W'(TCM_BYTES);

    logic [ADDR_W-1:0] ext_off;

    assign ext_off = addr - TCM_END;

    always_comb begin
        res = RES_IDLE;
        if (valid) begin
            res.valid = 1'b1;
            unique case (win)
                WIN_TCM: begin
                    res.tgt  = TGT_TCM;
                    res.addr = addr + TCM_OFFSET;
                end
                WIN_EXT: begin
                    res.tgt  = TGT_EXT;
                    res.addr = base + ext_off;
                end
                default: begin
                    res.err = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/cpdata_xlat.sv
module cpdata_xlat
    import xlat_pkg::*;
#(
    parameter int unsigned       TCM_BYTES   = 32768,
    parameter int unsigned       EXT_BYTES   = 4194304,
    parameter logic [31:0]       TCM_OFFSET  = 32'h0001_8000,
    parameter logic [31:0]       HIGH_OFFSET = 32'h4000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_base,
    input  logic        cfg_high,
    input  logic        in_valid,
    input  logic [31:0] in_addr,
    output logic        out_valid,
    output logic [1:0]  out_target,
    output logic [31:0] out_addr,
    output logic        out_err
);

    localparam logic [31:0] TCM_LO = TCM_OFFSET;
    localparam logic [31:0] TCM_HI = TCM_OFFSET + 32'(TCM_BYTES);

    logic [ADDR_W-1:0] base;
    win_e              win;
    xlat_res_s         res_d;
    xlat_res_s         res_q;

    xlat_base_reg #(
        .HIGH_OFFSET (HIGH_OFFSET)
    ) u_base (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_base),
        .high  (cfg_high),
        .base  (base)
    );

    xlat_classify #(
        .TCM_BYTES (TCM_BYTES),
        .EXT_BYTES (EXT_BYTES)
    ) u_classify (
        .addr (in_addr),
        .win  (win)
    );

    xlat_compose #(
        .TCM_BYTES  (TCM_BYTES),
        .TCM_OFFSET (TCM_OFFSET)
    ) u_compose (
        .valid (in_valid),
        .win   (win),
        .addr  (in_addr),
        .base  (base),
        .res   (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= RES_IDLE;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid  = res_q.valid;
    assign out_target = res_q.tgt;
    assign out_addr   = res_q.addr;
    assign out_err    = res_q.err;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2

    AST_ZERO_REJECTED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_addr == '0) |=> out_err); // R3

    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_target == TGT_IDLE && out_addr == '0)); // R9

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_err && out_target == TGT_IDLE && out_addr == '0)); // R9

    AST_TCM_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (out_target == TGT_TCM) |-> (out_addr > TCM_LO && out_addr < TCM_HI)); // R5

endmodule

// File: tb/test_cpdata_xlat.sv
module test_cpdata_xlat;

    localparam int unsigned TCM_B  = 64;
    localparam int unsigned EXT_B  = 256;
    localparam logic [31:0] TOFF   = 32'h0001_8000;
    localparam logic [31:0] HOFF   = 32'h4000_0000;
    localparam logic [31:0] LIMIT  = 32'(TCM_B + EXT_B);

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [31:0] cfg_base;
    logic        cfg_high;
    logic        in_valid;
    logic [31:0] in_addr;
    logic        out_valid;
    logic [1:0]  out_target;
    logic [31:0] out_addr;
    logic        out_err;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model_base;

    always #5 clk = ~clk;

    cpdata_xlat #(
        .TCM_BYTES   (TCM_B),
        .EXT_BYTES   (EXT_B),
        .TCM_OFFSET  (TOFF),
        .HIGH_OFFSET (HOFF)
    ) i_cpdata_xlat (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_base   (cfg_base),
        .cfg_high   (cfg_high),
        .in_valid   (in_valid),
        .in_addr    (in_addr),
        .out_valid  (out_valid),
        .out_target (out_target),
        .out_addr   (out_addr),
        .out_err    (out_err)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] composed(input logic [31:0] raw, input logic hi);
        return {raw[31:12], 12'h000} + (hi ? HOFF : 32'h0);
    endfunction

    task automatic write_cfg(input logic [31:0] raw, input logic hi);
        cfg_we   = 1'b1;
        cfg_base = raw;
        cfg_high = hi;
        @(posedge clk);
        #1;
        cfg_we     = 1'b0;
        model_base = composed(raw, hi);
    endtask

    task automatic xact(input logic [31:0] a, input string req);
        logic [1:0]  et;
        logic [31:0] ea;
        logic        ee;
        in_valid = 1'b1;
        in_addr  = a;
        @(posedge clk);
        #1;
        if (a == 0 || a > LIMIT) begin
            et = 2'd0; ea = 32'h0; ee = 1'b1;
        end else if (a < TCM_B) begin
            et = 2'd1; ea = a + TOFF; ee = 1'b0;
        end else begin
            et = 2'd2; ea = model_base + (a - TCM_B); ee = 1'b0;
        end
        chk(req, "valid",  {31'h0, out_valid}, 32'h1);
        chk(req, "target", {30'h0, out_target}, {30'h0, et});
        chk(req, "addr",   out_addr, ea);
        chk(req, "err",    {31'h0, out_err}, {31'h0, ee});
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a <= int'(LIMIT) + 8; a++) begin
            xact(32'(a), req);
        end
    endtask

    task automatic idle_check(input string req);
        in_valid = 1'b0;
        in_addr  = 32'h0000_0005;
        @(posedge clk);
        #1;
        chk(req, "idle valid",  {31'h0, out_valid}, 32'h0);
        chk(req, "idle target", {30'h0, out_target}, 32'h0);
        chk(req, "idle addr",   out_addr, 32'h0);
        chk(req, "idle err",    {31'h0, out_err}, 32'h0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_base = 32'hFFFF_FFFF; cfg_high = 1'b1;
        in_valid = 1'b1; in_addr = 32'h10;
        model_base = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs cleared under reset
        chk("R1", "rst valid",  {31'h0, out_valid}, 32'h0);
        chk("R1", "rst target", {30'h0, out_target}, 32'h0);
        chk("R1", "rst addr",   out_addr, 32'h0);
        chk("R1", "rst err",    {31'h0, out_err}, 32'h0);
        rst = 1'b0;
        in_valid = 1'b0;
        // R1: base is zero after reset
        xact(32'(TCM_B), "R1");
        idle_check("R2");
        // R3 R4 R5 R6: exhaustive sweep with reset base
        sweep("R6");
        idle_check("R9");
        // R7: low bits dropped
        write_cfg(32'h1234_5678, 1'b0);
        sweep("R7");
        // R8: high mode with wrap
        write_cfg(32'hFFFF_F123, 1'b1);
        sweep("R8");
        write_cfg(32'hC000_0ABC, 1'b1);
        xact(32'(TCM_B) + 32'd17, "R8");
        // R4: large addresses
        xact(32'hFFFF_FFFF, "R4");
        xact(32'h8000_0000, "R4");
        xact(LIMIT + 32'd1, "R4");
        xact(LIMIT, "R4");
        // R3: zero after valid traffic
        xact(32'h0, "R3");
        // R10: write at same edge as request uses old base
        in_valid = 1'b1;
        in_addr  = 32'(TCM_B) + 32'd5;
        cfg_we   = 1'b1;
        cfg_base = 32'h0ABC_D000;
        cfg_high = 1'b0;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        chk("R10", "same-edge addr", out_addr, model_base + 32'd5);
        model_base = 32'h0ABC_D000;
        xact(32'(TCM_B) + 32'd5, "R10");
        // R10: no write, inputs wiggle, base unchanged
        cfg_base = 32'h5555_5000;
        cfg_high = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        xact(32'(TCM_B) + 32'd9, "R10");
        idle_check("R9");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule